// File: doc/BRIEF.md
# Two-Wire Slave Shift Engine with Clock Stretching

This block is the slave-side bit engine of a two-wire serial bus with open-drain clock and data lines. It watches both lines through synchronizers, flags start and stop conditions, and samples data into an 8-bit shift register on each rising clock. A 4-bit counter steps on every clock edge, rising and falling. The block holds the clock line low when the counter wraps, and also on the first falling clock after a start. The bus master then waits until local control logic has serviced the event.

The block has no fixed protocol state machine. The controlling logic frames bytes and acknowledge bits by presetting the counter. A preset of 0 gives sixteen edges, one full byte. A preset of 14 gives two edges, one acknowledge bit. Address matching, the choice to acknowledge, and direction handling are all done by the controller. It uses simple strobes: it loads and reads the shift register, presets the counter, clears flags, and enables the data-line driver.

Top module: `twiShiftSlave`

## Requirements
- R1: After reset the shift register and counter read 0, all three flags are 0, and neither line is pulled low.
- R2: A falling SDA while SCL is high sets the start flag. The start interrupt equals the start flag ANDed with its enable.
- R3: While the start flag is set, the next falling SCL makes the block pull SCL low. The hold lasts until the controller pulses the start-clear strobe.
- R4: On each rising SCL the shift register moves one place toward its MSB and takes the SDA level into bit 0. The first bit received therefore ends up in bit 7.
- R5: The counter increments by one on every SCL edge, rising or falling. A counter write loads the given value and takes priority over an edge.
- R6: When an edge moves the counter from 15 to 0, the overflow flag sets and SCL is pulled low. The overflow-clear strobe clears the flag and releases SCL. The overflow interrupt equals the flag ANDed with its enable.
- R7: With the counter preset to 14, the block holds SCL again after exactly one bit (one rise and one fall). This is how the acknowledge bit is framed.
- R8: SDA is pulled low only when the driver enable is 1 and the output bit is 0. The output bit copies the shift register MSB only while SCL is low.
- R9: A rising SDA while SCL is high sets the stop flag and releases any SCL hold. The stop-clear strobe clears the flag.
- R10: SDA changes while SCL is low set neither the start flag nor the stop flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | SCL line level |
| sdaIn | input | 1 | SDA line level |
| sclPullLow | output | 1 | 1 drives SCL low (clock stretch) |
| sdaPullLow | output | 1 | 1 drives SDA low |
| wrData | input | 1 | Load strobe for the shift register |
| wrDataVal | input | 8 | Value to load into the shift register |
| rdData | output | 8 | Shift register contents |
| wrCount | input | 1 | Load strobe for the edge counter |
| wrCountVal | input | 4 | Counter preset value |
| countVal | output | 4 | Edge counter contents |
| sdaOutEn | input | 1 | Enables the SDA driver |
| clrStart | input | 1 | Clears the start flag and its hold |
| clrStop | input | 1 | Clears the stop flag |
| clrOvf | input | 1 | Clears the overflow flag and its hold |
| startIrqEn | input | 1 | Start interrupt enable |
| ovfIrqEn | input | 1 | Overflow interrupt enable |
| startFlag | output | 1 | Start condition seen |
| stopFlag | output | 1 | Stop condition seen |
| ovfFlag | output | 1 | Counter wrapped |
| irqStart | output | 1 | Start interrupt |
| irqOvf | output | 1 | Overflow interrupt |

## Verification
The master model drives three kinds of traffic.

- Received bytes with mixed bit values (0xA5, 0x3C) check that bit order and the shift direction are right.
- An acknowledge phase with the counter preset to 14 checks that single-bit framing differs from full-byte framing.
- A master read of 0x5A checks that the driven SDA levels reach the line and come back through the shift register.

The master changes SDA while SCL is low in every byte, which separates real start and stop detection from false triggers. The master honours clock stretching, so any missing or stuck hold shows up as a wrong count, a hang, or a missed overflow.

// File: rtl/twiShiftPkg.sv
package twiShiftPkg;
  typedef struct packed {
    logic shiftEn;   // rising SCL: sample SDA
    logic countEn;   // any SCL edge: step counter
    logic latchEn;   // SCL low: output bit may follow MSB
    logic sdaBit;    // synchronized SDA level
  } twiStrobe_t;
endpackage

// File: rtl/twiCtrl.sv
module twiCtrl
  import twiShiftPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic       clrStart,
  input  logic       clrStop,
  input  logic       clrOvf,
  input  logic       ovfPulse,
  output twiStrobe_t strb,
  output logic       startFlag,
  output logic       stopFlag,
  output logic       ovfFlag,
  output logic       sclPullLow
);
  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclS, sdaS, sclP, sdaP;
  logic startDet, stopDet, sclRise, sclFall;
  logic startHold, ovfHold;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclP    <= 1'b1;
      sdaP    <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
      sclP    <= sclS;
      sdaP    <= sdaS;
    end
  end

  assign sclS     = sclSync[SYNC_STAGES-1];
  assign sdaS     = sdaSync[SYNC_STAGES-1];
  assign startDet = sclS && sclP && sdaP && !sdaS;
  assign stopDet  = sclS && sclP && !sdaP && sdaS;
  assign sclRise  = sclS && !sclP;
  assign sclFall  = !sclS && sclP;

  always_comb begin
    strb.shiftEn = sclRise;
    strb.countEn = sclRise || sclFall;
    strb.latchEn = !sclS;
    strb.sdaBit  = sdaS;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startFlag <= 1'b0;
      stopFlag  <= 1'b0;
      ovfFlag   <= 1'b0;
      startHold <= 1'b0;
      ovfHold   <= 1'b0;
    end else begin
      if (startDet)      startFlag <= 1'b1;
      else if (clrStart) startFlag <= 1'b0;
      if (stopDet)       stopFlag <= 1'b1;
      else if (clrStop)  stopFlag <= 1'b0;
      if (ovfPulse)      ovfFlag <= 1'b1;
      else if (clrOvf)   ovfFlag <= 1'b0;

      if (stopDet || clrStart || !startFlag) startHold <= 1'b0;
      else if (sclFall)                      startHold <= 1'b1;

      if (ovfPulse)                ovfHold <= 1'b1;
      else if (clrOvf || stopDet)  ovfHold <= 1'b0;
    end
  end

  assign sclPullLow = startHold || ovfHold;

  a_r2_start_sets_flag: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> startFlag);
  a_r3_hold_needs_start: assert property (@(posedge clk) disable iff (!rstN)
    startHold |-> startFlag);
  a_r6_ovf_holds_scl: assert property (@(posedge clk) disable iff (!rstN)
    ovfPulse |=> (ovfFlag && sclPullLow));
  a_r9_stop_releases: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> (stopFlag && !sclPullLow));
  a_r10_no_start_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    (!sclS && !startFlag) |=> !startFlag);
endmodule

// File: rtl/twiData.sv
module twiData
  import twiShiftPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  twiStrobe_t        strb,
  input  logic              wrData,
  input  logic [DATA_W-1:0] wrDataVal,
  input  logic              wrCount,
  input  logic [CNT_W-1:0]  wrCountVal,
  input  logic              sdaOutEn,
  output logic [DATA_W-1:0] shiftReg,
  output logic [CNT_W-1:0]  count,
  output logic              ovfPulse,
  output logic              sdaPullLow
);
  localparam logic [CNT_W-1:0] CNT_TOP = '1;
  logic outLatch;

  assign ovfPulse = strb.countEn && !wrCount && (count == CNT_TOP);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      count    <= '0;
      outLatch <= 1'b1;
    end else begin
      if (wrData)            shiftReg <= wrDataVal;
      else if (strb.shiftEn) shiftReg <= {shiftReg[DATA_W-2:0], strb.sdaBit};
      if (wrCount)           count <= wrCountVal;
      else if (strb.countEn) count <= count + 1'b1;
      if (strb.latchEn)      outLatch <= shiftReg[DATA_W-1];
    end
  end

  assign sdaPullLow = sdaOutEn && !outLatch;

  a_r5_count_step: assert property (@(posedge clk) disable iff (!rstN)
    (strb.countEn && !wrCount) |=> count == $past(count) + 1'b1);
  a_r4_shift_in: assert property (@(posedge clk) disable iff (!rstN)
    (strb.shiftEn && !wrData) |=> shiftReg[0] == $past(strb.sdaBit));
  a_r8_latch_steady_scl_high: assert property (@(posedge clk) disable iff (!rstN)
    !strb.latchEn |=> $stable(outLatch));
endmodule

// File: rtl/twiShiftSlave.sv
module twiShiftSlave
  import twiShiftPkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int CNT_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sclPullLow,
  output logic              sdaPullLow,
  input  logic              wrData,
  input  logic [DATA_W-1:0] wrDataVal,
  output logic [DATA_W-1:0] rdData,
  input  logic              wrCount,
  input  logic [CNT_W-1:0]  wrCountVal,
  output logic [CNT_W-1:0]  countVal,
  input  logic              sdaOutEn,
  input  logic              clrStart,
  input  logic              clrStop,
  input  logic              clrOvf,
  input  logic              startIrqEn,
  input  logic              ovfIrqEn,
  output logic              startFlag,
  output logic              stopFlag,
  output logic              ovfFlag,
  output logic              irqStart,
  output logic              irqOvf
);
  twiStrobe_t strb;
  logic ovfPulse;

  twiCtrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .clrStart(clrStart), .clrStop(clrStop), .clrOvf(clrOvf),
    .ovfPulse(ovfPulse), .strb(strb), .startFlag(startFlag),
    .stopFlag(stopFlag), .ovfFlag(ovfFlag), .sclPullLow(sclPullLow)
  );

  twiData #(.DATA_W(DATA_W), .CNT_W(CNT_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .wrDataVal(wrDataVal), .wrCount(wrCount), .wrCountVal(wrCountVal),
    .sdaOutEn(sdaOutEn), .shiftReg(rdData), .count(countVal),
    .ovfPulse(ovfPulse), .sdaPullLow(sdaPullLow)
  );

  assign irqStart = startFlag && startIrqEn;
  assign irqOvf   = ovfFlag && ovfIrqEn;
endmodule

// File: tb/tb_twiShiftSlave.sv
module tb_twiShiftSlave;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclDrive = 1'b1, sdaDrive = 1'b1;
  logic sclLine, sdaLine, sclPullLow, sdaPullLow;
  logic wrData = 0, wrCount = 0, sdaOutEn = 0;
  logic clrStart = 0, clrStop = 0, clrOvf = 0;
  logic startIrqEn = 1, ovfIrqEn = 1;
  logic [7:0] wrDataVal = '0, rdData;
  logic [3:0] wrCountVal = '0, countVal;
  logic startFlag, stopFlag, ovfFlag, irqStart, irqOvf;
  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] expQ[$];
  logic prevOvf = 0;

  always #5 clk = ~clk;

  assign sclLine = sclDrive & ~sclPullLow;
  assign sdaLine = sdaDrive & ~sdaPullLow;

  twiShiftSlave dut (
    .clk(clk), .rstN(rstN), .sclIn(sclLine), .sdaIn(sdaLine),
    .sclPullLow(sclPullLow), .sdaPullLow(sdaPullLow),
    .wrData(wrData), .wrDataVal(wrDataVal), .rdData(rdData),
    .wrCount(wrCount), .wrCountVal(wrCountVal), .countVal(countVal),
    .sdaOutEn(sdaOutEn), .clrStart(clrStart), .clrStop(clrStop),
    .clrOvf(clrOvf), .startIrqEn(startIrqEn), .ovfIrqEn(ovfIrqEn),
    .startFlag(startFlag), .stopFlag(stopFlag), .ovfFlag(ovfFlag),
    .irqStart(irqStart), .irqOvf(irqOvf)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // master clocks one bit; returns SDA level seen at SCL high
  task automatic mbit(input logic b, output logic seen);
    sdaDrive = b;
    waitc(8);
    sclDrive = 1'b1;
    while (!sclLine) @(negedge clk);
    waitc(8);
    seen = sdaLine;
    sclDrive = 1'b0;
    waitc(8);
  endtask

  task automatic mbyte(input logic [7:0] v, output logic [7:0] seen);
    for (int i = 7; i >= 0; i--) mbit(v[i], seen[i]);
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: clrStart = 1'b1;
      1: clrStop  = 1'b1;
      default: clrOvf = 1'b1;
    endcase
    @(negedge clk);
    clrStart = 1'b0; clrStop = 1'b0; clrOvf = 1'b0;
    waitc(2);
  endtask

  task automatic loadCount(input logic [3:0] v);
    @(negedge clk); wrCount = 1'b1; wrCountVal = v;
    @(negedge clk); wrCount = 1'b0;
  endtask

  task automatic loadData(input logic [7:0] v);
    @(negedge clk); wrData = 1'b1; wrDataVal = v;
    @(negedge clk); wrData = 1'b0;
  endtask

  // scoreboard monitor: shift register contents at each overflow
  always @(negedge clk) begin
    if (rstN && ovfFlag && !prevOvf) begin
      if (expQ.size() == 0) begin
        checks++; errors++;
        $display("FAIL R6 actual=unexpected overflow expected=none");
      end else begin
        check("R4 byte at overflow", {24'd0, rdData}, {24'd0, expQ.pop_front()});
        check("R6 hold on overflow", {31'd0, sclPullLow}, 32'd1);
      end
    end
    prevOvf = ovfFlag;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic seen;
    logic [7:0] got;
    waitc(4);
    rstN = 1'b1;
    waitc(4);
    // R1 reset state
    check("R1 data", {24'd0, rdData}, 32'd0);
    check("R1 count", {28'd0, countVal}, 32'd0);
    check("R1 flags", {29'd0, startFlag, stopFlag, ovfFlag}, 32'd0);
    check("R1 pulls", {30'd0, sclPullLow, sdaPullLow}, 32'd0);

    // R2 start condition
    sdaDrive = 1'b0;
    waitc(8);
    check("R2 start flag", {31'd0, startFlag}, 32'd1);
    check("R2 start irq", {31'd0, irqStart}, 32'd1);
    check("R3 no hold before fall", {31'd0, sclPullLow}, 32'd0);
    // R3 hold on next falling SCL
    sclDrive = 1'b0;
    waitc(8);
    check("R3 hold after fall", {31'd0, sclPullLow}, 32'd1);
    check("R5 count after one edge", {28'd0, countVal}, 32'd1);
    loadCount(4'd0);
    pulse(0);
    check("R3 released by clear", {31'd0, sclPullLow}, 32'd0);
    check("R5 preset loaded", {28'd0, countVal}, 32'd0);

    // R4/R6 receive 0xA5 (scoreboard)
    expQ.push_back(8'hA5);
    mbyte(8'hA5, got);
    check("R6 flag", {31'd0, ovfFlag}, 32'd1);
    check("R6 irq", {31'd0, irqOvf}, 32'd1);
    check("R6 count wrapped", {28'd0, countVal}, 32'd0);
    check("R10 no start on low-SCL SDA change", {31'd0, startFlag}, 32'd0);
    check("R10 no stop on low-SCL SDA change", {31'd0, stopFlag}, 32'd0);

    // R7 acknowledge framing with preset 14
    loadData(8'h00);
    sdaOutEn = 1'b1;
    loadCount(4'd14);
    pulse(2);
    waitc(4);
    check("R8 ack pull", {31'd0, sdaPullLow}, 32'd1);
    expQ.push_back(8'h00);
    mbit(1'b1, seen);
    check("R7 ack seen low", {31'd0, seen}, 32'd0);
    check("R7 overflow after one bit", {31'd0, ovfFlag}, 32'd1);

    // second byte with driver off
    sdaOutEn = 1'b0;
    pulse(2);
    check("R6 released by clear", {31'd0, sclPullLow}, 32'd0);
    expQ.push_back(8'h3C);
    mbyte(8'h3C, got);
    check("R8 no pull when disabled", {31'd0, sdaPullLow}, 32'd0);

    // master read of 0x5A
    loadData(8'h5A);
    sdaOutEn = 1'b1;
    loadCount(4'd0);
    pulse(2);
    expQ.push_back(8'h5A);
    mbyte(8'hFF, got);
    check("R8 master read byte", {24'd0, got}, 32'h5A);

    // R9 stop
    sdaOutEn = 1'b0;
    pulse(2);
    sdaDrive = 1'b0;
    waitc(8);
    sclDrive = 1'b1;
    waitc(8);
    sdaDrive = 1'b1;
    waitc(8);
    check("R9 stop flag", {31'd0, stopFlag}, 32'd1);
    check("R9 no hold", {31'd0, sclPullLow}, 32'd0);
    pulse(1);
    check("R9 stop cleared", {31'd0, stopFlag}, 32'd0);
    check("R4 scoreboard drained", expQ.size(), 32'd0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule